// File: doc/BRIEF.md
# Disk Controller Command/Result Sequencer

This block is the host-facing byte engine of a disk controller. A single data port carries every byte in both directions, and a read-only main status byte tells the host when the port may be used and which way the next byte travels. The host writes an opcode and then its parameter bytes one at a time. The engine decodes the opcode from its low five bits and counts in the number of bytes that the command needs. For commands that touch a drive, it then hands off to an execution stub. Afterwards it offers result bytes for the host to read in order.

Media work is not part of this block. An execution phase is shown to the surrounding logic as `exec_req`, and the stub ends it with a one-cycle `exec_done` pulse. The completion status bytes are sampled from input ports in that same cycle. Commands that need no drive activity answer at once from their own inputs or from constants. These are the drive-status query, the interrupt-status query, the version query and unrecognised opcodes.

The sequencer has four states:
- `PH_IDLE` waits for an opcode.
- `PH_CMD` collects the parameter bytes.
- `PH_EXEC` waits for `exec_done`.
- `PH_RESULT` hands out the result bytes.

Its transitions are:
- IDLE to CMD on an opcode that needs parameters.
- IDLE to RESULT on a one-byte command.
- CMD to EXEC, CMD to RESULT or CMD to IDLE on the last command byte.
- EXEC to RESULT or EXEC to IDLE on `exec_done`.
- RESULT to IDLE on the read of the last result byte.

Top module: `dskc_cmd_engine`

## Requirements
- R1: After reset the engine is in PH_IDLE, `main_status` reads 80h and `exec_req` is 0.
- R2: `main_status` bits: bit 7 = port ready, bit 6 = direction (1 = engine to host), bit 5 = non-DMA flag, bit 4 = command busy, bits 3:0 = 0. The values per state are IDLE 80h, CMD 90h, RESULT D0h, and EXEC 10h (30h while `nondma_mode` is 1). Bit 5 is set only during EXEC.
- R3: Only bits 4:0 of the opcode select the command. Bits 7:5 have no effect on byte counts or results.
- R4: Low-five codes 02h, 05h, 06h, 09h, 0Ch, 11h, 19h and 1Dh take 9 bytes including the opcode, then enter EXEC. On `exec_done` the engine returns 7 bytes in this order: `ex_st0`, `ex_st1`, `ex_st2`, `ex_cyl`, `ex_head`, `ex_sec`, `ex_size`, as sampled in the `exec_done` cycle.
- R5: Code 0Ah takes 2 bytes and code 0Dh takes 6 bytes. Both execute and return the same 7-byte result as R4.
- R6: Code 03h (3 bytes), code 0Fh (3 bytes) and code 07h (2 bytes) enter EXEC. EXEC holds until `exec_done`, and the engine then returns straight to PH_IDLE with no result phase.
- R7: Code 04h takes 2 bytes, skips EXEC and returns one byte: `drv_st3` as sampled with the last command byte.
- R8: Code 08h is a 1-byte command. It returns `int_st0` and then `int_pcn`.
- R9: Code 10h is a 1-byte command that returns the single byte 90h.
- R10: Any other low-five code is a 1-byte command that returns the single byte 80h, whose bits 7:6 = 10 mark an invalid command.
- R11: A `host_rd` in IDLE or CMD, and a `host_wr` in EXEC or RESULT, are ignored. They leave the byte counters and the state unchanged.
- R12: `host_rdata` shows the current result byte during RESULT. Reading the last result byte returns the engine to PH_IDLE (80h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe for the data port |
| host_wdata | input | 8 | Byte written by the host |
| host_rd | input | 1 | Host read strobe; advances to the next result byte |
| host_rdata | output | 8 | Current result byte (0 outside RESULT) |
| main_status | output | 8 | Main status byte |
| exec_req | output | 1 | High while the execution phase is active |
| exec_done | input | 1 | One-cycle completion pulse from the execution stub |
| nondma_mode | input | 1 | Non-DMA mode flag shown in status bit 5 during EXEC |
| ex_st0 | input | 8 | Completion status byte 0 |
| ex_st1 | input | 8 | Completion status byte 1 |
| ex_st2 | input | 8 | Completion status byte 2 |
| ex_cyl | input | 8 | Completion cylinder |
| ex_head | input | 8 | Completion head |
| ex_sec | input | 8 | Completion sector |
| ex_size | input | 8 | Completion sector size code |
| drv_st3 | input | 8 | Drive status byte for the drive-status query |
| int_st0 | input | 8 | Status byte for the interrupt-status query |
| int_pcn | input | 8 | Present cylinder for the interrupt-status query |

## Verification
Every transfer opcode is sent with different flag bits in 7:5, so a decode that looks at more than five bits shows up as a wrong byte count. The short media commands, the no-result commands and the immediate-answer commands each take a different path through the four states. Checking the status byte after every byte separates off-by-one counting from wrong state choice. Completion inputs are changed after they should have been sampled, which exposes late capture. Stray reads during command entry, and stray writes during execution and result readout, would shift the byte count or the result order if they were not ignored.

// File: rtl/dskc_pkg.sv
package dskc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CMD,
        PH_EXEC,
        PH_RESULT
    } phase_e;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_MEDIA,
        RK_DRIVE,
        RK_SENSE,
        RK_VERSION,
        RK_INVALID
    } res_kind_e;

    localparam logic [7:0] VERSION_BYTE = 8'h90;
    localparam logic [7:0] INVALID_ST0  = 8'h80;

    localparam int MSR_RDY  = 7;
    localparam int MSR_DIR  = 6;
    localparam int MSR_NDMA = 5;
    localparam int MSR_BUSY = 4;

    // number of result bytes each result kind hands back
    function automatic int unsigned res_count(input res_kind_e k);
        case (k)
            RK_MEDIA:   return 7;
            RK_SENSE:   return 2;
            RK_DRIVE,
            RK_VERSION,
            RK_INVALID: return 1;
            default:    return 0;
        endcase
    endfunction

endpackage

// File: rtl/dskc_opcode_decode.sv
module dskc_opcode_decode
    import dskc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [4:0]       opc,
    output logic [CNT_W-1:0] cmd_len,
    output res_kind_e        kind,
    output logic             needs_exec
);

    // flag bits 7:5 never reach this module (R3)
    always_comb begin
        unique case (opc)
            5'h02, 5'h05, 5'h06, 5'h09,
            5'h0C, 5'h11, 5'h19, 5'h1D: begin
                cmd_len    = CNT_W'(9);
                kind       = RK_MEDIA;
                needs_exec = 1'b1;
            end
            5'h0A: begin
                cmd_len    = CNT_W'(2);
                kind       = RK_MEDIA;
                needs_exec = 1'b1;
            end
            5'h0D: begin
                cmd_len    = CNT_W'(6);
                kind       = RK_MEDIA;
                needs_exec = 1'b1;
            end
            5'h03, 5'h0F: begin
                cmd_len    = CNT_W'(3);
                kind       = RK_NONE;
                needs_exec = 1'b1;
            end
            5'h07: begin
                cmd_len    = CNT_W'(2);
                kind       = RK_NONE;
                needs_exec = 1'b1;
            end
            5'h04: begin
                cmd_len    = CNT_W'(2);
                kind       = RK_DRIVE;
                needs_exec = 1'b0;
            end
            5'h08: begin
                cmd_len    = CNT_W'(1);
                kind       = RK_SENSE;
                needs_exec = 1'b0;
            end
            5'h10: begin
                cmd_len    = CNT_W'(1);
                kind       = RK_VERSION;
                needs_exec = 1'b0;
            end
            default: begin
                cmd_len    = CNT_W'(1);
                kind       = RK_INVALID;
                needs_exec = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dskc_result_file.sv
module dskc_result_file #(
    parameter int NUM   = 7,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM*8-1:0] load_vec,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       rd_byte
);

    logic [NUM*8-1:0] slots_flat;

    for (genvar g = 0; g < NUM; g++) begin : g_slot
        logic [7:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (load) begin
                slot_q <= load_vec[g*8 +: 8];
            end
        end
        assign slots_flat[g*8 +: 8] = slot_q;
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NUM; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_byte = slots_flat[i*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/dskc_cmd_engine.sv
module dskc_cmd_engine
    import dskc_pkg::*;
#(
    parameter int MAX_CMD_BYTES = 9,
    parameter int MAX_RES_BYTES = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    input  logic       host_rd,
    output logic [7:0] host_rdata,
    output logic [7:0] main_status,
    output logic       exec_req,
    input  logic       exec_done,
    input  logic       nondma_mode,
    input  logic [7:0] ex_st0,
    input  logic [7:0] ex_st1,
    input  logic [7:0] ex_st2,
    input  logic [7:0] ex_cyl,
    input  logic [7:0] ex_head,
    input  logic [7:0] ex_sec,
    input  logic [7:0] ex_size,
    input  logic [7:0] drv_st3,
    input  logic [7:0] int_st0,
    input  logic [7:0] int_pcn
);

    localparam int CNT_W  = $clog2(MAX_CMD_BYTES + 1);
    localparam int RIDX_W = $clog2(MAX_RES_BYTES + 1);
    localparam int VEC_W  = MAX_RES_BYTES * 8;

    localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);
    localparam logic [RIDX_W-1:0] ONE_R = RIDX_W'(1);

    phase_e             state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, len_q;
    res_kind_e          kind_q;
    logic               exec_q;
    logic [RIDX_W-1:0]  ridx_q, rlen_q;

    logic [CNT_W-1:0]   dec_len;
    res_kind_e          dec_kind;
    logic               dec_exec;

    logic               load_res;
    res_kind_e          load_kind;
    logic [VEC_W-1:0]   load_vec;
    logic [7:0]         res_byte;

    dskc_opcode_decode #(
        .CNT_W (CNT_W)
    ) u_decode (
        .opc        (host_wdata[4:0]),
        .cmd_len    (dec_len),
        .kind       (dec_kind),
        .needs_exec (dec_exec)
    );

    dskc_result_file #(
        .NUM   (MAX_RES_BYTES),
        .IDX_W (RIDX_W)
    ) u_results (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_res),
        .load_vec (load_vec),
        .idx      (ridx_q),
        .rd_byte  (res_byte)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and result capture
    always_comb begin
        state_d   = state_q;
        load_res  = 1'b0;
        load_kind = kind_q;
        unique case (state_q)
            PH_IDLE: begin
                if (host_wr) begin
                    if (dec_len == ONE_C) begin
                        load_kind = dec_kind;
                        if (dec_exec) begin
                            state_d = PH_EXEC;
                        end else if (dec_kind == RK_NONE) begin
                            state_d = PH_IDLE;
                        end else begin
                            state_d  = PH_RESULT;
                            load_res = 1'b1;
                        end
                    end else begin
                        state_d = PH_CMD;
                    end
                end
            end
            PH_CMD: begin
                if (host_wr && (cnt_q + ONE_C == len_q)) begin
                    if (exec_q) begin
                        state_d = PH_EXEC;
                    end else if (kind_q == RK_NONE) begin
                        state_d = PH_IDLE;
                    end else begin
                        state_d  = PH_RESULT;
                        load_res = 1'b1;
                    end
                end
            end
            PH_EXEC: begin
                if (exec_done) begin
                    if (kind_q == RK_NONE) begin
                        state_d = PH_IDLE;
                    end else begin
                        state_d  = PH_RESULT;
                        load_res = 1'b1;
                    end
                end
            end
            PH_RESULT: begin
                if (host_rd && (ridx_q + ONE_R == rlen_q)) begin
                    state_d = PH_IDLE;
                end
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // bytes captured into the result file
    always_comb begin
        load_vec = '0;
        case (load_kind)
            RK_MEDIA: begin
                load_vec[0*8 +: 8] = ex_st0;
                load_vec[1*8 +: 8] = ex_st1;
                load_vec[2*8 +: 8] = ex_st2;
                load_vec[3*8 +: 8] = ex_cyl;
                load_vec[4*8 +: 8] = ex_head;
                load_vec[5*8 +: 8] = ex_sec;
                load_vec[6*8 +: 8] = ex_size;
            end
            RK_DRIVE:   load_vec[0 +: 8] = drv_st3;
            RK_SENSE: begin
                load_vec[0 +: 8] = int_st0;
                load_vec[8 +: 8] = int_pcn;
            end
            RK_VERSION: load_vec[0 +: 8] = VERSION_BYTE;
            RK_INVALID: load_vec[0 +: 8] = INVALID_ST0;
            default:    load_vec = '0;
        endcase
    end

    // byte counters and latched decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            len_q  <= '0;
            kind_q <= RK_NONE;
            exec_q <= 1'b0;
            ridx_q <= '0;
            rlen_q <= '0;
        end else begin
            if (state_q == PH_IDLE && host_wr) begin
                cnt_q  <= ONE_C;
                len_q  <= dec_len;
                kind_q <= dec_kind;
                exec_q <= dec_exec;
            end else if (state_q == PH_CMD && host_wr) begin
                cnt_q <= cnt_q + ONE_C;
            end
            if (load_res) begin
                ridx_q <= '0;
                rlen_q <= RIDX_W'(res_count(load_kind));
            end else if (state_q == PH_RESULT && host_rd) begin
                ridx_q <= ridx_q + ONE_R;
            end
        end
    end

    // outputs
    always_comb begin
        main_status = '0;
        host_rdata  = '0;
        exec_req    = 1'b0;
        unique case (state_q)
            PH_IDLE: begin
                main_status[MSR_RDY] = 1'b1;
            end
            PH_CMD: begin
                main_status[MSR_RDY]  = 1'b1;
                main_status[MSR_BUSY] = 1'b1;
            end
            PH_EXEC: begin
                main_status[MSR_BUSY] = 1'b1;
                main_status[MSR_NDMA] = nondma_mode;
                exec_req              = 1'b1;
            end
            PH_RESULT: begin
                main_status[MSR_RDY]  = 1'b1;
                main_status[MSR_DIR]  = 1'b1;
                main_status[MSR_BUSY] = 1'b1;
                host_rdata            = res_byte;
            end
            default: main_status = '0;
        endcase
    end

endmodule

// File: rtl/dskc_cmd_engine_chk.sv
module dskc_cmd_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic       host_rd,
    input logic [7:0] host_rdata,
    input logic [7:0] main_status,
    input logic       exec_req,
    input logic       exec_done,
    input logic       nondma_mode,
    input logic [7:0] ex_st0,
    input logic [7:0] ex_st1,
    input logic [7:0] ex_st2,
    input logic [7:0] ex_cyl,
    input logic [7:0] ex_head,
    input logic [7:0] ex_sec,
    input logic [7:0] ex_size,
    input logic [7:0] drv_st3,
    input logic [7:0] int_st0,
    input logic [7:0] int_pcn
);

    p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !main_status[4] |-> (main_status[7:6] == 2'b10) && !exec_req);

    p_result_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        main_status[6] |-> main_status[7] && main_status[4]);

    p_exec_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |-> !main_status[7] && !main_status[6] && main_status[4]);

    p_ndma_in_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        main_status[5] |-> exec_req);

    p_exec_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_req && !exec_done) |=> exec_req);

    p_read_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && main_status[7] && !main_status[6]) |=> $stable(main_status));

    p_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_rd && main_status[6]) |=> $stable(host_rdata) && $stable(main_status));

endmodule

bind dskc_cmd_engine dskc_cmd_engine_chk u_chk (.*);

// File: tb/dskc_cmd_engine_test.sv
`timescale 1ns/1ps
module dskc_cmd_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic [7:0] main_status;
    logic       exec_req;
    logic       exec_done = 1'b0;
    logic       nondma_mode = 1'b0;
    logic [7:0] ex_st0 = '0, ex_st1 = '0, ex_st2 = '0, ex_cyl = '0;
    logic [7:0] ex_head = '0, ex_sec = '0, ex_size = '0;
    logic [7:0] drv_st3 = '0, int_st0 = '0, int_pcn = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dskc_cmd_engine uut (.*);

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        host_wr    = 1'b1;
        host_wdata = b;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic rd(output logic [7:0] b);
        @(negedge clk);
        b       = host_rdata;
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
    endtask

    task automatic t_reset();
        chk(main_status, 8'h80, "R1 status after reset");
        chk({7'b0, exec_req}, 8'h00, "R1 exec_req after reset");
    endtask

    // 7-result commands: R3 flags, R4/R5 lengths, R2 status, R12 readout
    task automatic t_media(input logic [7:0] op, input int len, input string tag);
        logic [7:0] exp [7];
        logic [7:0] got;
        wr(op);
        for (int i = 1; i < len; i++) begin
            chk(main_status, 8'h90, {tag, " R2 status during command"});
            wr(8'(i));
        end
        chk(main_status, 8'h10, {tag, " R2 status in execution"});
        nondma_mode = 1'b1;
        #1;
        chk(main_status, 8'h30, {tag, " R2 non-DMA flag in execution"});
        nondma_mode = 1'b0;
        exp[0] = 8'h40; exp[1] = op; exp[2] = 8'h12; exp[3] = 8'h27;
        exp[4] = 8'h01; exp[5] = ~op; exp[6] = 8'h02;
        ex_st0 = exp[0]; ex_st1 = exp[1]; ex_st2 = exp[2]; ex_cyl = exp[3];
        ex_head = exp[4]; ex_sec = exp[5]; ex_size = exp[6];
        done_pulse();
        ex_st0 = 8'hEE; ex_st1 = 8'hEE; ex_cyl = 8'hEE; ex_size = 8'hEE;
        chk(main_status, 8'hD0, {tag, " R2 status in result"});
        for (int k = 0; k < 7; k++) begin
            rd(got);
            chk(got, exp[k], {tag, " R4 result byte"});
        end
        chk(main_status, 8'h80, {tag, " R12 idle after last result"});
    endtask

    task automatic t_no_result(input logic [7:0] op, input int len, input string tag);
        wr(op);
        for (int i = 1; i < len; i++) wr(8'h00);
        chk(main_status, 8'h10, {tag, " R6 enters execution"});
        repeat (5) @(negedge clk);
        chk({7'b0, exec_req}, 8'h01, {tag, " R6 execution holds"});
        done_pulse();
        chk(main_status, 8'h80, {tag, " R6 straight to idle"});
    endtask

    task automatic t_drive();
        logic [7:0] got;
        drv_st3 = 8'h28;
        wr(8'h04);
        chk(main_status, 8'h90, "R7 waits for parameter");
        wr(8'h01);
        drv_st3 = 8'hFF;
        chk(main_status, 8'hD0, "R7 result without execution");
        rd(got);
        chk(got, 8'h28, "R7 drive status byte");
        chk(main_status, 8'h80, "R7 idle after one byte");
    endtask

    task automatic t_sense();
        logic [7:0] got;
        int_st0 = 8'h21;
        int_pcn = 8'h4F;
        wr(8'h08);
        chk(main_status, 8'hD0, "R8 one-byte command");
        rd(got);
        chk(got, 8'h21, "R8 first byte status");
        rd(got);
        chk(got, 8'h4F, "R8 second byte cylinder");
        chk(main_status, 8'h80, "R8 idle after two bytes");
    endtask

    task automatic t_version();
        logic [7:0] got;
        wr(8'h10);
        rd(got);
        chk(got, 8'h90, "R9 version byte");
        chk(main_status, 8'h80, "R9 idle");
        wr(8'hF0);
        rd(got);
        chk(got, 8'h90, "R9 R3 version with flag bits");
    endtask

    task automatic t_invalid(input logic [7:0] op);
        logic [7:0] got;
        wr(op);
        chk(main_status, 8'hD0, "R10 invalid opcode result phase");
        rd(got);
        chk(got, 8'h80, "R10 invalid result byte");
        chk({6'b0, got[7:6]}, 8'h02, "R10 completion code invalid");
        chk(main_status, 8'h80, "R10 idle after invalid");
    endtask

    task automatic t_ignore();
        logic [7:0] got;
        wr(8'h06);
        @(negedge clk); host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
        chk(main_status, 8'h90, "R11 read in command phase ignored");
        for (int i = 1; i < 8; i++) wr(8'h33);
        chk(main_status, 8'h90, "R11 byte count unchanged by read");
        wr(8'h33);
        chk(main_status, 8'h10, "R11 ninth byte starts execution");
        wr(8'h55);
        chk(main_status, 8'h10, "R11 write in execution ignored");
        ex_st0 = 8'hA0; ex_st1 = 8'hA1; ex_st2 = 8'hA2; ex_cyl = 8'hA3;
        ex_head = 8'hA4; ex_sec = 8'hA5; ex_size = 8'hA6;
        done_pulse();
        rd(got);
        chk(got, 8'hA0, "R11 first result");
        wr(8'h08);
        chk(main_status, 8'hD0, "R11 write in result phase ignored");
        rd(got);
        chk(got, 8'hA1, "R11 result order kept after write");
        for (int k = 2; k < 7; k++) begin
            rd(got);
            chk(got, 8'hA0 + 8'(k), "R11 remaining results");
        end
        chk(main_status, 8'h80, "R12 idle after ignored traffic");
    endtask

    task automatic run_all();
        t_reset();
        t_media(8'hE6, 9, "read");
        t_media(8'h45, 9, "write");
        t_media(8'h8C, 9, "read deleted");
        t_media(8'h49, 9, "write deleted");
        t_media(8'h22, 9, "track");
        t_media(8'h31, 9, "scan eq");
        t_media(8'hB9, 9, "scan low");
        t_media(8'h1D, 9, "scan high");
        t_media(8'h4A, 2, "R5 id");
        t_media(8'h4D, 6, "R5 format");
        t_no_result(8'h03, 3, "specify");
        t_no_result(8'h0F, 3, "seek");
        t_no_result(8'h07, 2, "recal");
        t_drive();
        t_sense();
        t_version();
        t_invalid(8'h00);
        t_invalid(8'h1F);
        t_invalid(8'h14);
        t_invalid(8'hE1);
        t_ignore();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual hung expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule